// File: doc/BRIEF.md
# Progress Event Text Logger

This block turns progress events from a neighbouring controller into short ASCII records on an asynchronous serial transmit line. It holds one event at a time and asks for the next one only when the line has gone quiet. The controller therefore offers its events through a valid/ready pair and never writes into the logger's buffer. Each event becomes a fixed mnemonic: a letter, then any decimal or hexadecimal digits, then a carriage return and a line feed.

Characters go out as 8N1 frames. The bit time is `CLK_HZ / BAUD` clock cycles, and the default rate is 230400 bit/s. The first record after reset is a restart marker. The raw bytes of an unexpected response can be taken lowest byte first or highest byte first; a parameter selects which.

Top module: `progress_logger`

## Requirements
- R1: After reset is released the block sends "-" followed by CR (0x0D) and LF (0x0A) exactly once. `ev_ready` stays low until that record has left the line.
- R2: An event with `ev_kind` = 0 (plain command) sends 'C', then the tens digit and the units digit of `ev_index` as ASCII (0x30 to 0x39, leading zero kept), then CR LF.
- R3: An event with `ev_kind` = 1 (application command) sends 'A', then the two decimal digits of `ev_index`, then CR LF.
- R4: `ev_kind` = 2 sends "S" CR LF. `ev_kind` = 3 sends "E" CR LF.
- R5: `ev_kind` = 4 sends 'X', then the first `ev_raw_cnt` bytes of `ev_raw`, each as two uppercase hex digits (high nibble first, 10 to 15 as 'A' to 'F'), then CR LF. With the default order, byte 0 is `ev_raw[7:0]` and comes first. A count above `RAW_BYTES` is clamped to `RAW_BYTES`.
- R6: Each character is framed as one low start bit, eight data bits LSB first and one high stop bit. Every bit lasts CLK_HZ/BAUD cycles, and the line rests high.
- R7: `ev_ready` is high only when no record is pending and the stop bit of the last character has ended. The event is taken on the edge where `ev_valid` and `ev_ready` are both high. Its fields are captured at that edge, and `ev_ready` drops in the next cycle for kinds 0 to 4.
- R8: `ev_kind` codes 5, 6 and 7 are consumed without sending any character.
- R9: An `ev_index` above 99 is printed as "99".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Logger can take an event |
| ev_kind | input | 3 | Event code (0 cmd, 1 app cmd, 2 ok, 3 crc error, 4 unexpected) |
| ev_index | input | 7 | Command index, printed in decimal |
| ev_raw | input | 8*RAW_BYTES | Unexpected response bytes |
| ev_raw_cnt | input | $clog2(RAW_BYTES+1) | Number of raw bytes to dump |
| tx | output | 1 | Serial transmit line |

## Verification
The bench decodes the serial line and compares every character with the text it derives from each event. It covers indices 0, 8, 99 and 120. A divider that was off or unclamped would print a wrong digit or a non-digit. It dumps raw bytes containing nibbles above 9, so a hex map that was off would print punctuation instead of letters, and a reversed byte order would show up at once. It also sends a zero count, an over-range count and an unused kind; a design that ran past the byte array or printed something for the unused code would emit extra characters. The bench changes the event fields right after each handshake and checks that `ev_ready` never rises while characters are still owed. Together these catch a logger that samples late or overlaps records.

// File: rtl/log_pkg.sv
package log_pkg;

   typedef enum logic [2:0] {
      EV_CMD   = 3'd0,
      EV_APP   = 3'd1,
      EV_OK    = 3'd2,
      EV_CRC   = 3'd3,
      EV_UNEXP = 3'd4
   } ev_kind_e;

   typedef enum logic [2:0] {
      REC_MARK,
      REC_CMD,
      REC_APP,
      REC_OK,
      REC_CRC,
      REC_UNEXP
   } rec_e;

   localparam logic [7:0] CH_CR    = 8'h0D;
   localparam logic [7:0] CH_LF    = 8'h0A;
   localparam logic [7:0] CH_DASH  = 8'h2D;
   localparam logic [7:0] CH_ZERO  = 8'h30;

   function automatic logic [7:0] hex_ascii(input logic [3:0] n);
      if (n < 4'd10) return CH_ZERO + {4'd0, n};
      return 8'h41 + {4'd0, n - 4'd10};
   endfunction

   function automatic logic [6:0] dec_clamp(input logic [6:0] v);
      return (v > 7'd99) ? 7'd99 : v;
   endfunction

   // divide by ten through multiply by 103 and shift by 10, exact for 0..99
   function automatic logic [3:0] dec_tens(input logic [6:0] v);
      logic [13:0] p;
      p = 14'(dec_clamp(v)) * 14'd103;
      return p[13:10];
   endfunction

   function automatic logic [3:0] dec_units(input logic [6:0] v);
      logic [6:0] r;
      r = dec_clamp(v) - 7'(dec_tens(v)) * 7'd10;
      return r[3:0];
   endfunction

endpackage

// File: rtl/log_uart_tx.sv
module log_uart_tx #(
   parameter int CLKS_PER_BIT = 434
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   output logic       in_ready,
   output logic       tx
);
   localparam int CW     = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
   localparam int FRAME  = 10;

   logic [FRAME-1:0] shreg;
   logic [CW-1:0]    tick;
   logic [3:0]       nbit;
   logic             busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '1;
         tick  <= '0;
         nbit  <= '0;
         busy  <= 1'b0;
      end else if (!busy) begin
         if (in_valid) begin
            shreg <= {1'b1, in_data, 1'b0};
            tick  <= '0;
            nbit  <= '0;
            busy  <= 1'b1;
         end
      end else if (tick == CW'(CLKS_PER_BIT - 1)) begin
         tick  <= '0;
         shreg <= {1'b1, shreg[FRAME-1:1]};
         if (nbit == 4'(FRAME - 1)) busy <= 1'b0;
         else                       nbit <= nbit + 4'd1;
      end else begin
         tick <= tick + CW'(1);
      end
   end

   assign in_ready = !busy;
   assign tx       = shreg[0];

endmodule

// File: rtl/log_fmt.sv
module log_fmt
   import log_pkg::*;
#(
   parameter int RAW_BYTES     = 4,
   parameter bit RAW_MSB_FIRST = 1'b0,
   localparam int RAW_W        = RAW_BYTES * 8,
   localparam int CNT_W        = $clog2(RAW_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_valid,
   output logic             ev_ready,
   input  logic [2:0]       ev_kind,
   input  logic [6:0]       ev_index,
   input  logic [RAW_W-1:0] ev_raw,
   input  logic [CNT_W-1:0] ev_raw_cnt,
   input  logic             line_idle,
   output logic             ch_valid,
   output logic [7:0]       ch_data,
   input  logic             ch_ready
);
   localparam int POS_W = $clog2(2 * RAW_BYTES + 3);

   logic [7:0]       raw_in [RAW_BYTES];
   logic [7:0]       raw_q  [RAW_BYTES];
   logic             busy;
   rec_e             rec;
   logic [6:0]       idx_q;
   logic [POS_W-1:0] pos;
   logic [POS_W-1:0] last_q;
   logic [CNT_W-1:0] cnt_eff;

   genvar g;
   generate
      for (g = 0; g < RAW_BYTES; g++) begin : g_byte
         if (RAW_MSB_FIRST) begin : g_hi
            assign raw_in[g] = ev_raw[(RAW_BYTES-1-g)*8 +: 8];
         end else begin : g_lo
            assign raw_in[g] = ev_raw[g*8 +: 8];
         end
      end
   endgenerate

   assign cnt_eff  = (ev_raw_cnt > CNT_W'(RAW_BYTES)) ? CNT_W'(RAW_BYTES) : ev_raw_cnt;
   assign ev_ready = !busy && line_idle;
   assign ch_valid = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b1;
         rec    <= REC_MARK;
         pos    <= '0;
         last_q <= POS_W'(2);
         idx_q  <= '0;
         for (int i = 0; i < RAW_BYTES; i++) raw_q[i] <= '0;
      end else if (busy) begin
         if (ch_ready) begin
            if (pos == last_q) busy <= 1'b0;
            else               pos  <= pos + POS_W'(1);
         end
      end else if (ev_valid && ev_ready) begin
         pos   <= '0;
         idx_q <= ev_index;
         for (int i = 0; i < RAW_BYTES; i++) raw_q[i] <= raw_in[i];
         case (ev_kind_e'(ev_kind))
            EV_CMD:   begin busy <= 1'b1; rec <= REC_CMD; last_q <= POS_W'(4); end
            EV_APP:   begin busy <= 1'b1; rec <= REC_APP; last_q <= POS_W'(4); end
            EV_OK:    begin busy <= 1'b1; rec <= REC_OK;  last_q <= POS_W'(2); end
            EV_CRC:   begin busy <= 1'b1; rec <= REC_CRC; last_q <= POS_W'(2); end
            EV_UNEXP: begin
               busy   <= 1'b1;
               rec    <= REC_UNEXP;
               last_q <= POS_W'(2) + (POS_W'(cnt_eff) << 1);
            end
            default:  busy <= 1'b0;
         endcase
      end
   end

   logic [POS_W-1:0] k;
   logic [7:0]       sel;
   logic [3:0]       nib;

   always_comb begin
      k   = pos - POS_W'(1);
      sel = '0;
      for (int i = 0; i < RAW_BYTES; i++)
         if (k[POS_W-1:1] == (POS_W-1)'(i)) sel = raw_q[i];
      nib = k[0] ? sel[3:0] : sel[7:4];

      if (pos == last_q)               ch_data = CH_LF;
      else if (pos == last_q - POS_W'(1)) ch_data = CH_CR;
      else begin
         case (rec)
            REC_MARK: ch_data = CH_DASH;
            REC_CMD, REC_APP: begin
               if (pos == '0)              ch_data = (rec == REC_CMD) ? 8'h43 : 8'h41;
               else if (pos == POS_W'(1))  ch_data = CH_ZERO + {4'd0, dec_tens(idx_q)};
               else                        ch_data = CH_ZERO + {4'd0, dec_units(idx_q)};
            end
            REC_OK:   ch_data = 8'h53;
            REC_CRC:  ch_data = 8'h45;
            default:  ch_data = (pos == '0) ? 8'h58 : hex_ascii(nib);
         endcase
      end
   end

endmodule

// File: rtl/progress_logger.sv
module progress_logger
   import log_pkg::*;
#(
   parameter int CLK_HZ        = 100_000_000,
   parameter int BAUD          = 230_400,
   parameter int RAW_BYTES     = 4,
   parameter bit RAW_MSB_FIRST = 1'b0,
   localparam int CLKS_PER_BIT = CLK_HZ / BAUD,
   localparam int RAW_W        = RAW_BYTES * 8,
   localparam int CNT_W        = $clog2(RAW_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_valid,
   output logic             ev_ready,
   input  logic [2:0]       ev_kind,
   input  logic [6:0]       ev_index,
   input  logic [RAW_W-1:0] ev_raw,
   input  logic [CNT_W-1:0] ev_raw_cnt,
   output logic             tx
);
   initial begin
      assert (RAW_BYTES >= 1 && RAW_BYTES <= 64)
         else $error("RAW_BYTES out of range");
      assert (CLKS_PER_BIT >= 2)
         else $error("clock too slow for the baud rate");
   end

   logic       ch_valid;
   logic       ch_ready;
   logic [7:0] ch_data;
   logic       line_idle;

   log_fmt #(
      .RAW_BYTES     (RAW_BYTES),
      .RAW_MSB_FIRST (RAW_MSB_FIRST)
   ) u_fmt (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_valid   (ev_valid),
      .ev_ready   (ev_ready),
      .ev_kind    (ev_kind),
      .ev_index   (ev_index),
      .ev_raw     (ev_raw),
      .ev_raw_cnt (ev_raw_cnt),
      .line_idle  (line_idle),
      .ch_valid   (ch_valid),
      .ch_data    (ch_data),
      .ch_ready   (ch_ready)
   );

   log_uart_tx #(
      .CLKS_PER_BIT (CLKS_PER_BIT)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (ch_valid),
      .in_data  (ch_data),
      .in_ready (ch_ready),
      .tx       (tx)
   );

   assign line_idle = ch_ready;

endmodule

// File: rtl/log_checker.sv
module log_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       ev_valid,
   input logic       ev_ready,
   input logic       tx,
   input logic       ch_valid,
   input logic       ch_ready,
   input logic [7:0] ch_data,
   input logic       line_idle
);
   // R7: offering readiness only with a quiet, idle line
   a_r7_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ready |-> (tx && line_idle));

   // R7: readiness never overlaps a pending character (covers the R1 marker)
   a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      ch_valid |-> !ev_ready);

   // R6: a character waiting for the transmitter does not change
   a_r6_char_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_valid && !ch_ready) |=> (ch_valid && $stable(ch_data)));

   // R6: accepting a character starts a low start bit
   a_r6_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_valid && ch_ready) |=> !tx);

   // R6: the transmitter stays busy for the cycle after an accept
   a_r6_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_valid && ch_ready) |=> !line_idle);

endmodule

bind progress_logger log_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_valid  (ev_valid),
   .ev_ready  (ev_ready),
   .tx        (tx),
   .ch_valid  (ch_valid),
   .ch_ready  (ch_ready),
   .ch_data   (ch_data),
   .line_idle (line_idle)
);

// File: tb/sim_progress_logger.sv
module sim_progress_logger;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 2_304_000;
   localparam int BAUD       = 230_400;
   localparam int CPB        = CLK_HZ / BAUD;
   localparam int RAW_BYTES  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic        ev_ready;
   logic [2:0]  ev_kind = '0;
   logic [6:0]  ev_index = '0;
   logic [31:0] ev_raw = '0;
   logic [2:0]  ev_raw_cnt = '0;
   logic        tx;

   int total = 0;
   int bad   = 0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   progress_logger #(
      .CLK_HZ    (CLK_HZ),
      .BAUD      (BAUD),
      .RAW_BYTES (RAW_BYTES)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_valid   (ev_valid),
      .ev_ready   (ev_ready),
      .ev_kind    (ev_kind),
      .ev_index   (ev_index),
      .ev_raw     (ev_raw),
      .ev_raw_cnt (ev_raw_cnt),
      .tx         (tx)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [7:0] hexc(input int n);
      return (n < 10) ? 8'(8'h30 + n) : 8'(8'h41 + n - 10);
   endfunction

   task automatic push(input logic [7:0] c, input string tag);
      exp_q.push_back(c);
      tag_q.push_back(tag);
   endtask

   task automatic push_crlf(input string tag);
      push(8'h0D, tag);
      push(8'h0A, tag);
   endtask

   // scoreboard monitor: decodes frames and compares with expected text
   initial begin
      logic [7:0] got;
      wait (rst_n);
      forever begin
         @(negedge clk);
         if (tx === 1'b0) begin
            repeat (CPB/2 - 1) @(negedge clk);
            check(tx == 1'b0, "R6", "start bit", int'(tx), 0);
            for (int b = 0; b < 8; b++) begin
               repeat (CPB) @(negedge clk);
               got[b] = tx;
            end
            repeat (CPB) @(negedge clk);
            check(tx == 1'b1, "R6", "stop bit", int'(tx), 1);
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", "unexpected character", int'(got), 0);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(got == e, t, "character", int'(got), int'(e));
            end
         end
      end
   end

   task automatic send(input logic [2:0] k, input logic [6:0] idx,
                       input logic [31:0] raw, input logic [2:0] cnt,
                       input string tag);
      int eff;
      int d;
      @(negedge clk);
      ev_kind = k; ev_index = idx; ev_raw = raw; ev_raw_cnt = cnt;
      ev_valid = 1'b1;
      while (!ev_ready) @(negedge clk);
      // R7: no character from the previous record may still be owed
      check(exp_q.size() == 0, "R7", "ready before record done", exp_q.size(), 0);
      d = (idx > 99) ? 99 : int'(idx);
      case (k)
         3'd0, 3'd1: begin
            push((k == 3'd0) ? 8'h43 : 8'h41, tag);
            push(8'(8'h30 + d / 10), tag);
            push(8'(8'h30 + d % 10), tag);
            push_crlf(tag);
         end
         3'd2: begin push(8'h53, tag); push_crlf(tag); end
         3'd3: begin push(8'h45, tag); push_crlf(tag); end
         3'd4: begin
            eff = (cnt > RAW_BYTES) ? RAW_BYTES : int'(cnt);
            push(8'h58, tag);
            for (int i = 0; i < eff; i++) begin
               push(hexc(int'(raw[i*8+4 +: 4])), tag);
               push(hexc(int'(raw[i*8 +: 4])), tag);
            end
            push_crlf(tag);
         end
         default: ;
      endcase
      @(negedge clk);
      ev_valid = 1'b0;
      ev_kind = 3'd2; ev_index = 7'h55; ev_raw = 32'h1234_5678; ev_raw_cnt = 3'd3;
      if (k <= 3'd4)
         check(ev_ready == 1'b0, "R7", "ready after accept", int'(ev_ready), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(tx == 1'b1, "R6", "line idle in reset", int'(tx), 1);
      check(ev_ready == 1'b0, "R1", "ready in reset", int'(ev_ready), 0);
      push(8'h2D, "R1"); push_crlf("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check(ev_ready == 1'b0, "R1", "ready during marker", int'(ev_ready), 0);

      send(3'd0, 7'd0,   '0, '0, "R2");
      send(3'd0, 7'd8,   '0, '0, "R2");
      send(3'd0, 7'd99,  '0, '0, "R2");
      send(3'd0, 7'd120, '0, '0, "R9");
      send(3'd1, 7'd41,  '0, '0, "R3");
      send(3'd1, 7'd6,   '0, '0, "R3");
      send(3'd2, 7'd0,   '0, '0, "R4");
      send(3'd3, 7'd0,   '0, '0, "R4");
      send(3'd4, 7'd0,   32'h0000_A53C, 3'd2, "R5");
      send(3'd4, 7'd0,   32'hDEAD_BEEF, 3'd4, "R5");
      send(3'd4, 7'd0,   32'hFFFF_FFFF, 3'd0, "R5");
      send(3'd4, 7'd0,   32'h0A1B_2C3D, 3'd7, "R5");
      send(3'd6, 7'd12,  32'hFFFF_FFFF, 3'd4, "R8");
      send(3'd5, 7'd33,  '0, '0, "R8");
      send(3'd2, 7'd0,   '0, '0, "R8");

      while (exp_q.size() != 0 || !ev_ready) @(negedge clk);
      check(tx == 1'b1, "R6", "line idle at end", int'(tx), 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule